// File: doc/BRIEF.md
# Wake Interrupt Sensitivity Detector

This block watches four external interrupt pins and turns each one into a wake-up request for the power controller. Each channel has an enable bit and a 3-bit sensitivity mode. The mode selects low level, high level, falling edge, rising edge or both edges. Each pin is resynchronised to the block clock before any detection is done. Edge requests stay latched until software pulses that channel's clear strobe. Level requests follow the synchronised pin for as long as the channel is enabled.

A 2-bit status field is kept for each channel. When the channel is set for both edges, the field records which direction of edge raised the request, so the wake handler can find out what woke the system. All four channels share one 32-bit control word with one byte per channel. The word is written through a single write strobe and read back combinationally. Software must set the mode in one write and turn on the enable in a later write. If a single write tries to change both, the block drops the enable change.

Top module: `wake_sense_top`

## Requirements
- R1: After reset every channel byte reads 0x20: enable 0, status 00, mode 010. Every request output is 0.
- R2: Channel i occupies bits 8i+7..8i of the word. Bit 0 is the enable, bits 3:2 are the status, bits 6:4 are the mode, and bits 1 and 7 read 0. Write data in bits 1, 3:2 and 7 has no effect.
- R3: Mode codes 101, 110 and 111 are reserved. A write that carries one of them leaves the stored mode unchanged, and the enable bit in that write still takes effect.
- R4: In mode 100 (both edges), an enabled channel ORs 01 into its status on a rising edge and 10 on a falling edge, so seeing both edges gives 11. In any other mode the status is never updated.
- R5: A one-cycle pulse on a channel's clear input empties that channel's pending edge request and sets its status to 00.
- R6: If a write changes a channel's mode to a different legal code, the enable bit in that same write is ignored.
- R7: In the edge modes (010 falling, 011 rising, 100 either edge), a matching edge raises the request on the third clock edge after the pin changes. The request stays high until it is cleared.
- R8: In mode 000 the request is the inverted synchronised pin, and in mode 001 it is the synchronised pin. Either way it follows a pin change by two clock edges.
- R9: A channel whose enable is 0 drives its request low, discards any pending edge request, and registers no new edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data, one byte per channel |
| reg_rdata | output | 32 | Current control word, combinational |
| clr | input | 4 | Per-channel clear of request and status |
| pin_in | input | 4 | Asynchronous interrupt pins |
| wake_req | output | 4 | Per-channel wake-up request |

## Verification
A register write is visible on the read port right after the clock edge that captures it. A level request follows a pin change after two clock edges. An edge request and the status update follow after three clock edges. After each stimulus the bench waits four full clock periods, which is past every one of these latencies, and then samples on the falling edge. A bench model works out the expected word and request vector from the edges the bench itself drove, and the sweep runs every channel through all five modes.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam logic [2:0] MODE_LOW  = 3'b000;
  localparam logic [2:0] MODE_HIGH = 3'b001;
  localparam logic [2:0] MODE_FALL = 3'b010;
  localparam logic [2:0] MODE_RISE = 3'b011;
  localparam logic [2:0] MODE_BOTH = 3'b100;
  localparam logic [2:0] MODE_RST  = MODE_FALL;

  function automatic logic mode_legal(input logic [2:0] m);
    return m <= MODE_BOTH;
  endfunction

  function automatic logic is_level(input logic [2:0] m);
    return m[2:1] == 2'b00;
  endfunction

  function automatic logic level_match(input logic [2:0] m, input logic s);
    return (m == MODE_LOW) ? ~s : s;
  endfunction

  function automatic logic edge_match(input logic [2:0] m, input logic rise,
                                      input logic fall);
    case (m)
      MODE_FALL: return fall;
      MODE_RISE: return rise;
      MODE_BOTH: return rise | fall;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] status_merge(input logic [1:0] st, input logic rise,
                                              input logic fall);
    return st | {fall, rise};
  endfunction

  function automatic logic [7:0] pack_byte(input logic en, input logic [1:0] st,
                                           input logic [2:0] m);
    return {1'b0, m, st, 1'b0, en};
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_in;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign d_out = stg[STAGES-1];
endmodule

// File: rtl/wake_chan.sv
module wake_chan
  import wake_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  input  logic       clr,
  input  logic       s_cur,
  output logic       en,
  output logic [2:0] mode,
  output logic [1:0] st,
  output logic       req,
  output logic       hit
);
  logic       s_prev;
  logic       pend;
  logic       rise, fall;
  logic [2:0] mode_new;
  logic       mode_take, mode_moves;

  assign mode_new   = wr_byte[6:4];
  assign mode_take  = wr_en && mode_legal(mode_new);
  assign mode_moves = mode_take && (mode_new != mode);

  assign rise = s_cur & ~s_prev;
  assign fall = ~s_cur & s_prev;
  assign hit  = en && edge_match(mode, rise, fall);
  assign req  = en && (is_level(mode) ? level_match(mode, s_cur) : pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_prev <= 1'b0;
      mode   <= MODE_RST;
      en     <= 1'b0;
      st     <= 2'b00;
      pend   <= 1'b0;
    end else begin
      s_prev <= s_cur;
      if (mode_take) mode <= mode_new;
      if (wr_en && !mode_moves) en <= wr_byte[0];
      if (clr || !en)  pend <= 1'b0;
      else if (hit)    pend <= 1'b1;
      if (clr)                            st <= 2'b00;
      else if (en && mode == MODE_BOTH)   st <= status_merge(st, rise, fall);
    end
  end
endmodule

// File: rtl/wake_sense_top.sv
module wake_sense_top
  import wake_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [8*NCH-1:0] reg_wdata,
  output logic [8*NCH-1:0] reg_rdata,
  input  logic [NCH-1:0]  clr,
  input  logic [NCH-1:0]  pin_in,
  output logic [NCH-1:0]  wake_req
);
  logic [NCH-1:0]   pin_s;
  logic [NCH-1:0]   ch_en;
  logic [NCH-1:0]   ch_hit;
  logic [3*NCH-1:0] ch_mode;
  logic [2*NCH-1:0] ch_st;

  wake_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .d_out(pin_s)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wake_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_wr),
      .wr_byte(reg_wdata[8*i +: 8]),
      .clr    (clr[i]),
      .s_cur  (pin_s[i]),
      .en     (ch_en[i]),
      .mode   (ch_mode[3*i +: 3]),
      .st     (ch_st[2*i +: 2]),
      .req    (wake_req[i]),
      .hit    (ch_hit[i])
    );
    assign reg_rdata[8*i +: 8] = pack_byte(ch_en[i], ch_st[2*i +: 2], ch_mode[3*i +: 3]);
  end
endmodule

// File: rtl/wake_sense_chk.sv
module wake_sense_chk
  import wake_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [8*NCH-1:0] reg_wdata,
  input logic [NCH-1:0]   clr,
  input logic [NCH-1:0]   wake_req,
  input logic [NCH-1:0]   ch_en,
  input logic [NCH-1:0]   ch_hit,
  input logic [3*NCH-1:0] ch_mode,
  input logic [2*NCH-1:0] ch_st
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R3
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_legal(ch_mode[3*i +: 3]));
    // R6
    combined_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && mode_legal(reg_wdata[8*i+4 +: 3]) &&
       reg_wdata[8*i+4 +: 3] != ch_mode[3*i +: 3]) |=> ch_en[i] == $past(ch_en[i]));
    // R5
    clear_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> ch_st[2*i +: 2] == 2'b00);
    // R9
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |-> !wake_req[i]);
    // R4
    status_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_st[2*i +: 2] != $past(ch_st[2*i +: 2]) && ch_st[2*i +: 2] != 2'b00)
        |-> $past(ch_mode[3*i +: 3]) == MODE_BOTH);
    // R7
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_hit[i] && !clr[i] && !reg_wr) |=> wake_req[i]);
  end
endmodule

bind wake_sense_top wake_sense_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .clr(clr),
  .wake_req(wake_req), .ch_en(ch_en), .ch_hit(ch_hit), .ch_mode(ch_mode), .ch_st(ch_st)
);

// File: tb/wake_sense_top_bench.sv
module wake_sense_top_bench;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic             reg_wr;
  logic [8*NCH-1:0] reg_wdata;
  logic [8*NCH-1:0] reg_rdata;
  logic [NCH-1:0]   clr;
  logic [NCH-1:0]   pin_in;
  logic [NCH-1:0]   wake_req;

  wake_sense_top u_wake_sense_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .clr(clr), .pin_in(pin_in), .wake_req(wake_req)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [2:0] sh_mode [NCH];
  logic       sh_en   [NCH];
  logic       ex_pend [NCH];
  logic [1:0] ex_st   [NCH];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    for (int c = 0; c < NCH; c++)
      w[8*c +: 8] = {1'b0, sh_mode[c], ex_st[c], 1'b0, sh_en[c]};
    return w;
  endfunction

  function automatic logic [NCH-1:0] exp_req();
    logic [NCH-1:0] r = '0;
    for (int c = 0; c < NCH; c++) begin
      if (!sh_en[c])             r[c] = 1'b0;
      else if (sh_mode[c] == 0)  r[c] = ~pin_in[c];
      else if (sh_mode[c] == 1)  r[c] = pin_in[c];
      else                       r[c] = ex_pend[c];
    end
    return r;
  endfunction

  task automatic check_all(input string tag);
    chk({tag, " word"}, reg_rdata, exp_word());
    chk({tag, " req"}, {28'd0, wake_req}, {28'd0, exp_req()});
  endtask

  // Writes raw byte for one channel; other bytes rebuilt from the model.
  // Read-only bits 1, 3:2 and 7 are always written as ones (R2).
  task automatic wr_raw(input int ch, input logic [2:0] m, input logic e);
    logic [31:0] d;
    for (int c = 0; c < NCH; c++)
      d[8*c +: 8] = {1'b1, sh_mode[c], 2'b11, 1'b1, sh_en[c]};
    d[8*ch +: 8] = {1'b1, m, 2'b11, 1'b1, e};
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    if (m <= 3'b100 && m != sh_mode[ch]) sh_mode[ch] = m;   // R6: enable ignored
    else begin
      sh_en[ch] = e;                                         // R3: enable applies
      if (m <= 3'b100) sh_mode[ch] = m;
    end
    if (!sh_en[ch]) ex_pend[ch] = 1'b0;
  endtask

  task automatic cfg(input int ch, input logic [2:0] m, input logic e);
    wr_raw(ch, m, sh_en[ch]);
    wr_raw(ch, m, e);
  endtask

  task automatic set_pin(input int ch, input logic v);
    logic old, r, f, hitm;
    @(negedge clk);
    old = pin_in[ch];
    pin_in[ch] = v;
    r = v & ~old;
    f = ~v & old;
    if (sh_en[ch]) begin
      hitm = (sh_mode[ch] == 3'b010 && f) || (sh_mode[ch] == 3'b011 && r) ||
             (sh_mode[ch] == 3'b100 && (r || f));
      if (hitm) ex_pend[ch] = 1'b1;
      if (sh_mode[ch] == 3'b100) ex_st[ch] = ex_st[ch] | {f, r};
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_clr(input int ch);
    @(negedge clk);
    clr[ch] = 1'b1;
    @(negedge clk);
    clr[ch] = 1'b0;
    ex_pend[ch] = 1'b0;
    ex_st[ch] = 2'b00;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; clr = '0; pin_in = '0;
    for (int c = 0; c < NCH; c++) begin
      sh_mode[c] = 3'b010; sh_en[c] = 1'b0; ex_pend[c] = 1'b0; ex_st[c] = 2'b00;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset word", reg_rdata, 32'h2020_2020);
    chk("R1 reset req", {28'd0, wake_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 post-reset");

    // Sweep: every channel through every legal mode (R2 R4 R5 R7 R8 R9)
    for (int ch = 0; ch < NCH; ch++) begin
      for (int m = 0; m < 5; m++) begin
        cfg(ch, 3'(m), 1'b1);
        check_all("R2 config");
        pulse_clr(ch);
        check_all("R5 cleared");
        set_pin(ch, 1'b1);
        check_all("R7 R8 R4 rise");
        pulse_clr(ch);
        check_all("R5 clear after rise");
        set_pin(ch, 1'b0);
        check_all("R7 R8 R4 fall");
        set_pin(ch, 1'b1);
        check_all("R4 both edges seen");
        pulse_clr(ch);
        check_all("R5 clear status");
        set_pin(ch, 1'b0);
        check_all("R7 fall after clear");
        cfg(ch, 3'(m), 1'b0);
        check_all("R9 disabled");
        set_pin(ch, 1'b1);
        check_all("R9 disabled rise");
        set_pin(ch, 1'b0);
        check_all("R9 disabled fall");
        pulse_clr(ch);
      end
    end

    // R6: mode and enable changed in one write, enable ignored
    cfg(1, 3'b011, 1'b0);
    wr_raw(1, 3'b100, 1'b1);
    check_all("R6 combined write");
    chk("R6 enable stays 0", {31'd0, reg_rdata[8]}, 32'd0);

    // R3: reserved codes leave the mode, enable still applies
    wr_raw(2, 3'b101, 1'b1);
    check_all("R3 reserved 101");
    wr_raw(2, 3'b111, 1'b0);
    check_all("R3 reserved 111");
    wr_raw(2, 3'b110, 1'b1);
    chk("R3 mode kept", {29'd0, reg_rdata[22:20]}, {29'd0, sh_mode[2]});

    finish_run();
  end
endmodule